// File: doc/BRIEF.md
# Instruction Fetch and Classification Unit

This unit reads 18-bit instruction words from a word-addressed memory port with one request in flight at a time. Each word is sorted by its 6-bit function code (bits 17:12) into one of four instruction kinds. For the two-word kind it fetches the second word before presenting the result. The decoded fields, together with the address of the instruction, are offered to downstream logic over a valid/ready handshake.

The unit keeps a 17-bit instruction address. After each instruction is accepted, it moves that address past the instruction, and one word further when the consumer asks for a skip. A plain binary carry takes sequential flow from the last word of a 4096-word bay into the next bay, and from the top of the space back to address 0. Function codes that mean nothing are not presented. They raise a one-cycle flag, and fetching resumes at the following word.

Top module: `ifu_top`

## Requirements
- R1: While `rst` is high, `dec_valid` and `illegal_op` are 0. In the first cycle after `rst` falls, `mem_req` is 1 and `mem_addr` equals the `RESET_VEC` parameter (default 0x00FFE).
- R2: Function codes octal 02–027, 032, 033 and 040–047 are presented with `dec_kind` = 0. `dec_u` is word bits 11:0, `dec_minor` is 0, and `dec_ix` equals function bit 0.
- R3: Function codes octal 030, 031, 034–037 and 051–076 are presented with `dec_kind` = 1. `dec_u` is bits 11:0, `dec_minor` is 0, `dec_ix` is 0, and `dec_z` is `dec_u` sign-extended from bit 11 to 18 bits.
- R4: Function code octal 050 with a minor code (bits 11:6) whose bit in `MINOR_MASK` is 0 is a one-word instruction presented with `dec_kind` = 2. `dec_minor` is bits 11:6, the constant K appears in `dec_u[5:0]`, and `dec_ix` is 0.
- R5: Function code octal 050 with a minor code whose `MINOR_MASK` bit is 1 (by default octal 040–077) causes a second fetch at address+1. It is presented with `dec_kind` = 3. `dec_u` is bits 11:0 of the second word and `dec_ix` is bit 12 of the second word. Bits 17:13 of the second word are ignored.
- R6: Function codes 00, 01 and 077 are never presented. Each raises `illegal_op` for exactly one cycle, and fetching continues at the next word.
- R7: While `dec_valid` is 1 and `dec_ready` is 0, every `dec_*` output holds its value.
- R8: An accepted instruction without a skip is followed by a fetch at its address plus its length (1 or 2). From the last word of a bay this reaches word 0 of the next bay.
- R9: `dec_skip` high during acceptance adds one more word. From the last word of a bay this reaches word 1 of the next bay.
- R10: Address arithmetic wraps from 0x1FFFF to 0x00000, including the second-word fetch and skips.
- R11: `mem_req` is never high in two consecutive cycles. Each request is answered by one `mem_rvalid` before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request to instruction memory |
| mem_addr | output | 17 | Word address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 18 | Read data word |
| dec_valid | output | 1 | Decoded instruction available |
| dec_ready | input | 1 | Consumer accepts the instruction |
| dec_skip | input | 1 | Skip the following word, sampled on acceptance |
| dec_kind | output | 2 | 0 type I, 1 type II, 2 type III one-word, 3 type III two-word |
| dec_func | output | 6 | Function code |
| dec_minor | output | 6 | Minor code for kinds 2 and 3, otherwise 0 |
| dec_u | output | 12 | Operand field |
| dec_z | output | 18 | Operand field sign-extended |
| dec_ix | output | 1 | Indexing flag |
| dec_addr | output | 17 | Address of the first word of the instruction |
| illegal_op | output | 1 | One-cycle pulse for an undefined function code |

## Verification
The bench walks across a bay boundary with a plain step and with a skip placed on the last word of the top bay. A design with a truncated carry would re-fetch inside the same bay, or fail to wrap to address 0. The bench places a two-word instruction with junk in the unused high bits of its second word, and a skipped two-word instruction followed by a trap word. It also tests the boundary minor codes octal 037 and 040. A wrong length or mask lookup shows up as a trap word in the scoreboard or as a wrong operand. It stalls the consumer on a regular pattern and feeds three undefined codes in a row, so any unheld output, merged pulse or unadvanced address is visible.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int MINOR_W   = 6;
    localparam int MINOR_CNT = 2 ** MINOR_W;

    typedef enum logic [1:0] {
        KIND_T1  = 2'd0,
        KIND_T2  = 2'd1,
        KIND_T3A = 2'd2,
        KIND_T3B = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_REQ1  = 3'd0,
        ST_WAIT1 = 3'd1,
        ST_REQ2  = 3'd2,
        ST_WAIT2 = 3'd3,
        ST_OUT   = 3'd4
    } fsm_e;

    // Returns {undefined, kind}; code 050 is reported as one-word, refined later by the minor mask.
    function automatic logic [2:0] code_class(input int c);
        logic [2:0] r;
        if (c == 'o0 || c == 'o1 || c == 'o77)
            r = {1'b1, KIND_T1};
        else if (c == 'o50)
            r = {1'b0, KIND_T3A};
        else if (c == 'o30 || c == 'o31 || (c >= 'o34 && c <= 'o37) ||
                 (c >= 'o51 && c <= 'o76))
            r = {1'b0, KIND_T2};
        else
            r = {1'b0, KIND_T1};
        return r;
    endfunction

endpackage

// File: rtl/ifu_classify.sv
module ifu_classify
    import ifu_pkg::*;
#(
    parameter int FUNC_W = 6,
    parameter logic [MINOR_CNT-1:0] MINOR_MASK = {{(MINOR_CNT/2){1'b1}}, {(MINOR_CNT/2){1'b0}}}
) (
    input  logic [FUNC_W-1:0]  func,
    input  logic [MINOR_W-1:0] minor,
    output kind_e              kind,
    output logic               illegal
);
    localparam int NCODES = 2 ** FUNC_W;

    logic [2:0] code_tab [NCODES];

    // one constant table entry per function code
    for (genvar g = 0; g < NCODES; g++) begin : g_tab
        assign code_tab[g] = code_class(g);
    end

    logic [2:0] cls;

    always_comb begin
        cls     = code_tab[func];
        illegal = cls[2];
        kind    = kind_e'(cls[1:0]);
        if (kind == KIND_T3A && MINOR_MASK[minor])
            kind = KIND_T3B;
    end

endmodule

// File: rtl/ifu_pc_step.sv
module ifu_pc_step #(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        inc,
    output logic [ADDR_W-1:0] next
);
    // plain modular add: the carry out of the low word bits moves into the bay bits,
    // and the carry out of the top bit is dropped
    always_comb begin
        next = base + ADDR_W'(inc);
    end

endmodule

// File: rtl/ifu_fields.sv
module ifu_fields
    import ifu_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int FUNC_W = 6,
    localparam int OPND_W = WORD_W - FUNC_W
) (
    input  kind_e               kind,
    input  logic [WORD_W-1:0]   w1,
    input  logic [OPND_W-1:0]   u2,
    input  logic                ix2,
    output logic [FUNC_W-1:0]   func,
    output logic [MINOR_W-1:0]  minor,
    output logic [OPND_W-1:0]   u,
    output logic [WORD_W-1:0]   z,
    output logic                ix
);
    always_comb begin
        func = w1[WORD_W-1 -: FUNC_W];
        u    = (kind == KIND_T3B) ? u2 : w1[OPND_W-1:0];
        z    = {{(WORD_W-OPND_W){u[OPND_W-1]}}, u};
        unique case (kind)
            KIND_T1: begin
                minor = '0;
                ix    = func[0];
            end
            KIND_T2: begin
                minor = '0;
                ix    = 1'b0;
            end
            KIND_T3A: begin
                minor = w1[OPND_W-1 -: MINOR_W];
                ix    = 1'b0;
            end
            default: begin
                minor = w1[OPND_W-1 -: MINOR_W];
                ix    = ix2;
            end
        endcase
    end

endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int WORD_W = 18,
    parameter int FUNC_W = 6,
    parameter logic [ADDR_W-1:0] RESET_VEC = 17'h00FFE,
    parameter logic [MINOR_CNT-1:0] MINOR_MASK = {{(MINOR_CNT/2){1'b1}}, {(MINOR_CNT/2){1'b0}}}
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     dec_valid,
    input  logic                     dec_ready,
    input  logic                     dec_skip,
    output logic [1:0]               dec_kind,
    output logic [FUNC_W-1:0]        dec_func,
    output logic [MINOR_W-1:0]       dec_minor,
    output logic [WORD_W-FUNC_W-1:0] dec_u,
    output logic [WORD_W-1:0]        dec_z,
    output logic                     dec_ix,
    output logic [ADDR_W-1:0]        dec_addr,
    output logic                     illegal_op
);
    localparam int OPND_W = WORD_W - FUNC_W;

    typedef struct packed {
        fsm_e              st;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] w1;
        logic [OPND_W-1:0] u2;
        logic              ix2;
        kind_e             kind;
        logic              illg;
    } state_t;

    state_t cur_q, nxt_d;

    kind_e             cls_kind_d;
    logic              cls_illegal_d;
    logic [ADDR_W-1:0] pc_plus1_d, pc_adv_d;
    logic [1:0]        adv_inc_d;

    ifu_classify #(
        .FUNC_W    (FUNC_W),
        .MINOR_MASK(MINOR_MASK)
    ) u_cls (
        .func   (mem_rdata[WORD_W-1 -: FUNC_W]),
        .minor  (mem_rdata[OPND_W-1 -: MINOR_W]),
        .kind   (cls_kind_d),
        .illegal(cls_illegal_d)
    );

    ifu_pc_step #(.ADDR_W(ADDR_W)) u_step1 (
        .base(cur_q.pc),
        .inc (2'd1),
        .next(pc_plus1_d)
    );

    // length of the instruction plus one more word when a skip is taken
    assign adv_inc_d = 2'd1 + {1'b0, cur_q.kind == KIND_T3B} + {1'b0, dec_skip};

    ifu_pc_step #(.ADDR_W(ADDR_W)) u_stepn (
        .base(cur_q.pc),
        .inc (adv_inc_d),
        .next(pc_adv_d)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.illg = 1'b0;
        unique case (cur_q.st)
            ST_REQ1: nxt_d.st = ST_WAIT1;
            ST_WAIT1: begin
                if (mem_rvalid) begin
                    nxt_d.w1   = mem_rdata;
                    nxt_d.kind = cls_kind_d;
                    if (cls_illegal_d) begin
                        nxt_d.illg = 1'b1;
                        nxt_d.pc   = pc_plus1_d;
                        nxt_d.st   = ST_REQ1;
                    end else if (cls_kind_d == KIND_T3B) begin
                        nxt_d.st = ST_REQ2;
                    end else begin
                        nxt_d.st = ST_OUT;
                    end
                end
            end
            ST_REQ2: nxt_d.st = ST_WAIT2;
            ST_WAIT2: begin
                if (mem_rvalid) begin
                    nxt_d.u2  = mem_rdata[OPND_W-1:0];
                    nxt_d.ix2 = mem_rdata[OPND_W];
                    nxt_d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (dec_ready) begin
                    nxt_d.pc = pc_adv_d;
                    nxt_d.st = ST_REQ1;
                end
            end
            default: nxt_d.st = ST_REQ1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            cur_q.st <= ST_REQ1;
            cur_q.pc <= RESET_VEC;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_req    = (cur_q.st == ST_REQ1) || (cur_q.st == ST_REQ2);
    assign mem_addr   = (cur_q.st == ST_REQ2) ? pc_plus1_d : cur_q.pc;
    assign dec_valid  = (cur_q.st == ST_OUT);
    assign dec_kind   = cur_q.kind;
    assign dec_addr   = cur_q.pc;
    assign illegal_op = cur_q.illg;

    ifu_fields #(
        .WORD_W(WORD_W),
        .FUNC_W(FUNC_W)
    ) u_fields (
        .kind (cur_q.kind),
        .w1   (cur_q.w1),
        .u2   (cur_q.u2),
        .ix2  (cur_q.ix2),
        .func (dec_func),
        .minor(dec_minor),
        .u    (dec_u),
        .z    (dec_z),
        .ix   (dec_ix)
    );

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_req && mem_addr == RESET_VEC)); // R1
    AST_NO_BACK_TO_BACK_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R11
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_func) && $stable(dec_u)
                                       && $stable(dec_addr) && $stable(dec_kind))); // R7
    AST_ILLEGAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> !illegal_op); // R6
    AST_ILLEGAL_NOT_PRESENTED: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_func != 6'o0 && dec_func != 6'o1 && dec_func != 6'o77)); // R6
    AST_STEP_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready && !dec_skip && dec_kind != 2'd3)
        |=> (mem_req && mem_addr == ADDR_W'($past(dec_addr) + 1'b1))); // R8
    AST_STEP_SKIP: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready && dec_skip && dec_kind != 2'd3)
        |=> (mem_req && mem_addr == ADDR_W'($past(dec_addr) + 2'd2))); // R9

endmodule

// File: tb/sim_ifu_top.sv
module sim_ifu_top;

    typedef struct packed {
        logic [16:0] addr;
        logic [1:0]  kind;
        logic [5:0]  func;
        logic [5:0]  minor;
        logic [11:0] u;
        logic [17:0] z;
        logic        ix;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [17:0] mem [int];

    function automatic logic [17:0] rd(input logic [16:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 18'h0;
    endfunction

    // ---------------- instance u0 ----------------
    logic        mem_req, mem_rvalid, dec_valid, dec_ready, dec_skip, dec_ix, illegal_op;
    logic [16:0] mem_addr, dec_addr;
    logic [17:0] mem_rdata, dec_z;
    logic [1:0]  dec_kind;
    logic [5:0]  dec_func, dec_minor;
    logic [11:0] dec_u;

    ifu_top u0 (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .dec_skip(dec_skip), .dec_kind(dec_kind),
        .dec_func(dec_func), .dec_minor(dec_minor), .dec_u(dec_u), .dec_z(dec_z),
        .dec_ix(dec_ix), .dec_addr(dec_addr), .illegal_op(illegal_op)
    );

    // ---------------- instance u1: top of address space ----------------
    logic        mem_req1, mem_rvalid1, dec_valid1, dec_skip1, dec_ix1, illegal_op1;
    logic [16:0] mem_addr1, dec_addr1;
    logic [17:0] mem_rdata1, dec_z1;
    logic [1:0]  dec_kind1;
    logic [5:0]  dec_func1, dec_minor1;
    logic [11:0] dec_u1;

    ifu_top #(.RESET_VEC(17'h1FFFF)) u1 (
        .clk(clk), .rst(rst), .mem_req(mem_req1), .mem_addr(mem_addr1),
        .mem_rvalid(mem_rvalid1), .mem_rdata(mem_rdata1), .dec_valid(dec_valid1),
        .dec_ready(1'b1), .dec_skip(dec_skip1), .dec_kind(dec_kind1),
        .dec_func(dec_func1), .dec_minor(dec_minor1), .dec_u(dec_u1), .dec_z(dec_z1),
        .dec_ix(dec_ix1), .dec_addr(dec_addr1), .illegal_op(illegal_op1)
    );

    // one-cycle memory models
    always @(posedge clk) begin
        mem_rvalid  <= mem_req && !rst;
        mem_rdata   <= rd(mem_addr);
        mem_rvalid1 <= mem_req1 && !rst;
        mem_rdata1  <= rd(mem_addr1);
    end

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ill_cnt = 0;
    int n1 = 0;
    exp_t  exp_q [$];
    string tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // expected fields derived from the requirement text
    function automatic exp_t make_exp(input logic [16:0] a, input logic [17:0] w1,
                                      input logic [17:0] w2, input logic [1:0] k);
        exp_t e;
        e.addr  = a;
        e.kind  = k;
        e.func  = w1[17:12];
        e.minor = (k >= 2'd2) ? w1[11:6] : 6'd0;
        e.u     = (k == 2'd3) ? w2[11:0] : w1[11:0];
        e.z     = {{6{e.u[11]}}, e.u};
        e.ix    = (k == 2'd0) ? w1[12] : (k == 2'd3) ? w2[12] : 1'b0;
        return e;
    endfunction

    // driver: writes the program and pushes the expected item
    task automatic put1(input logic [16:0] a, input logic [17:0] w, input logic [1:0] k, input string tag);
        mem[int'(a)] = w;
        exp_q.push_back(make_exp(a, w, 18'h0, k));
        tag_q.push_back(tag);
    endtask

    task automatic put2(input logic [16:0] a, input logic [17:0] w1, input logic [17:0] w2, input string tag);
        mem[int'(a)]     = w1;
        mem[int'(a) + 1] = w2;
        exp_q.push_back(make_exp(a, w1, w2, 2'd3));
        tag_q.push_back(tag);
    endtask

    function automatic logic [17:0] w3(input logic [5:0] minor, input logic [5:0] k);
        return {6'o50, minor, k};
    endfunction

    // ---------------- monitor u0 ----------------
    bit   prev_req = 0, prev_ill = 0, stalled = 0;
    exp_t held;
    exp_t act;

    always @(negedge clk) begin
        cyc++;
        act = {dec_addr, dec_kind, dec_func, dec_minor, dec_u, dec_z, dec_ix};
        if (rst) begin
            prev_req = 0;
            prev_ill = 0;
            stalled  = 0;
        end else begin
            if (mem_req) check(!prev_req, "R11 request spacing", 64'(mem_req), 64'd0);
            prev_req = mem_req;
            if (illegal_op) begin
                ill_cnt++;
                check(!prev_ill, "R6 pulse width", 64'd2, 64'd1);
            end
            prev_ill = illegal_op;
            if (stalled)
                check(dec_valid && act == held, "R7 hold under stall", 64'(act), 64'(held));
            dec_ready = (cyc % 3) != 1;
            dec_skip  = (dec_addr == 17'h01007);
            if (dec_valid && dec_ready && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, 64'(act), 64'(e));
            end
            stalled = dec_valid && !dec_ready;
            held    = act;
        end
    end

    // ---------------- monitor u1 ----------------
    exp_t act1;
    exp_t e1a, e1b;

    always @(negedge clk) begin
        act1      = {dec_addr1, dec_kind1, dec_func1, dec_minor1, dec_u1, dec_z1, dec_ix1};
        dec_skip1 = (dec_addr1 == 17'h1FFFF);
        if (!rst && dec_valid1 && n1 < 2) begin
            n1++;
            if (n1 == 1) check(act1 == e1a, "R2 top word", 64'(act1), 64'(e1a));
            else         check(act1 == e1b, "R9 R10 skip wraps to word 1", 64'(act1), 64'(e1b));
        end
    end

    initial begin
        dec_ready = 1'b0;
        dec_skip  = 1'b0;
        dec_skip1 = 1'b0;

        // u0 program, reset vector 0x00FFE
        put1(17'h00FFE, {6'o11, 12'h123}, 2'd0, "R1 first fetch at reset vector");
        put1(17'h00FFF, {6'o60, 12'h800}, 2'd1, "R3 type II negative Z");
        put1(17'h01000, {6'o12, 12'h7FF}, 2'd0, "R8 bay crossing word 0");
        mem[32'h01001] = 18'h0;
        mem[32'h01002] = {6'o77, 12'hFFF};
        mem[32'h01003] = {6'o01, 12'h555};
        put1(17'h01004, w3(6'o05, 6'o52), 2'd2, "R4 one-word type III after skipped codes");
        put2(17'h01005, w3(6'o45, 6'o00), {5'b10101, 1'b1, 12'hABC}, "R5 two-word, high bits ignored");
        put2(17'h01007, w3(6'o40, 6'o17), {5'b00000, 1'b0, 12'h001}, "R5 minor 040 boundary");
        mem[32'h01009] = {6'o20, 12'h000};
        put1(17'h0100A, {6'o31, 12'h07F}, 2'd1, "R9 skip past two-word");
        put1(17'h0100B, {6'o47, 12'h001}, 2'd0, "R2 odd code sets ix");
        put1(17'h0100C, {6'o51, 12'hFFF}, 2'd1, "R3 code 051");
        put1(17'h0100D, w3(6'o37, 6'o77), 2'd2, "R4 minor 037 boundary");
        for (int i = 'h100E; i < 'h1020; i++) mem[i] = {6'o02, 12'h000};

        // u1 program, reset vector 0x1FFFF
        mem[32'h1FFFF] = {6'o13, 12'h0AA};
        mem[32'h00000] = {6'o20, 12'h000};
        mem[32'h00001] = w3(6'o77, 6'o00);
        mem[32'h00002] = {5'h1F, 1'b0, 12'hFFF};
        e1a = make_exp(17'h1FFFF, {6'o13, 12'h0AA}, 18'h0, 2'd0);
        e1b = make_exp(17'h00001, w3(6'o77, 6'o00), {5'h1F, 1'b0, 12'hFFF}, 2'd3);

        repeat (4) @(negedge clk);
        check(!dec_valid && !illegal_op, "R1 outputs idle in reset",
              64'({dec_valid, illegal_op}), 64'd0);
        rst = 1'b0;
        #1;
        check(mem_req && mem_addr == 17'h00FFE, "R1 reset vector request",
              64'({mem_req, mem_addr}), 64'({1'b1, 17'h00FFE}));
        check(mem_req1 && mem_addr1 == 17'h1FFFF, "R1 reset vector request u1",
              64'({mem_req1, mem_addr1}), 64'({1'b1, 17'h1FFFF}));

        while ((exp_q.size() != 0 || n1 < 2) && cyc < 20000) @(negedge clk);
        if (cyc >= 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", exp_q.size(), 0);
        end
        check(ill_cnt == 3, "R6 undefined code count", 64'(ill_cnt), 64'd3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule